// File: doc/BRIEF.md
# Run-Time Tap-Selectable Galois Shift Register

This block is an eight-stage pseudorandom sequence generator built in internal-XOR form. Each link between neighbouring stages is set by its own bit of a tap mask to act either as a plain wire or as an XOR with the feedback bit, which is the output of the last stage. The mask is read on every advance, so software or surrounding logic can pick the generator polynomial while the block is running. No clock divider is included. A slower advance rate comes from a single-cycle step strobe on the one system clock.

The first stage keeps its bit inverted in storage. Reset clears every flip-flop, but the visible state after reset is therefore one in stage 1 and zero in all other stages. This puts the register on a non-zero seed, so it never starts in the all-zero lock-up state. Reset is asynchronous and active-low. Its assertion takes effect at once, and its release is synchronised to the clock. The block does not check whether the chosen mask is primitive.

Top module: `galois_tap_lfsr`

## Requirements
- R1: While `rst_n` is low, `lfsr_q` reads 8'h01 (bit 0 is stage 1, the only stage holding one), at once and regardless of `step`. After `rst_n` rises, the first two clock edges do not advance the register. The third edge is the first that can advance it.
- R2: On an edge where `step` is low, `lfsr_q` keeps its value, whatever `tap_sel` does. A new `tap_sel` value is used from the next edge where `step` is high.
- R3: On an edge where `step` is high, bit 0 of `lfsr_q` loads `tap_sel[0] & lfsr_q[7]`. This means stage 1 takes the feedback bit or constant zero.
- R4: On an edge where `step` is high, bit i (i = 1..7) of `lfsr_q` loads `lfsr_q[i-1] ^ (tap_sel[i] & lfsr_q[7])`.
- R5: An all-zero state stays all-zero for any `tap_sel` and any number of steps.
- R6: With `tap_sel` = 8'h1D (feedback into stage 1, and XORs on the links into stages 3, 4 and 5), the reset seed returns after exactly 255 steps and not before.
- R7: With `tap_sel` = 8'h12, stage 1 clears on the first step. The state after that first step then recurs after exactly 127 steps, which is a seven-bit maximal sequence.
- R8: With `tap_sel` = 8'h01 (feedback into stage 1 and wires elsewhere), the state rotates towards bit 7 and the seed returns after 8 steps.
- R9: With `tap_sel` = 8'h00, the seed walks out of the register, and the state is all zeros after 8 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step | input | 1 | Advance strobe; the register moves one step on edges where it is high |
| tap_sel | input | 8 | Per-link tap enables; bit 0 feeds stage 1, bit i sets the link into stage i+1 |
| lfsr_q | output | 8 | Visible register state; bit 0 is stage 1, bit 7 is the feedback stage |

## Verification
A chained vector table moves the register through masks that switch at every step: all taps, no taps, rotation only, and the two maximal masks. It also mixes in held steps. This separates the feedback path into stage 1 from the XOR links, and it catches a mask that is used before or after the edge it belongs to. Full-period runs with 8'h1D and 8'h12 tell a correct polynomial mapping from a bit-reversed or shifted one, because only the right mapping gives exactly 255 and 127. The rotation and clear-out masks separate the wire links from the XOR links. The all-zero case shows that no tap setting can leave the lock-up state. Resetting with the step strobe held high shows that reset wins and that its release is delayed.

// File: rtl/glfsr_pkg.sv
package glfsr_pkg;
  localparam int unsigned GLFSR_WIDTH    = 8;
  localparam int unsigned GLFSR_SYNC_LEN = 2;
endpackage

// File: rtl/glfsr_rst_sync.sv
module glfsr_rst_sync #(
  parameter int unsigned STAGES = glfsr_pkg::GLFSR_SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

  a_r1_sync_low_in_reset: assert property (@(posedge clk) !rst_n |-> !rst_sync_n)
    else $error("rst_sync_n high while rst_n low");
endmodule

// File: rtl/glfsr_link.sv
module glfsr_link #(
  parameter bit FIRST = 1'b0
) (
  input  logic prev_q,
  input  logic fb,
  input  logic tap_en,
  output logic link_d
);
  generate
    if (FIRST) begin : g_head
      assign link_d = tap_en & fb;
    end else begin : g_body
      assign link_d = prev_q ^ (tap_en & fb);
    end
  endgenerate
endmodule

// File: rtl/glfsr_stage.sv
module glfsr_stage #(
  parameter bit INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic d,
  output logic q
);
  logic store_q;
  logic store_d;
  logic d_enc;

  assign d_enc = INVERT ? ~d : d;

  always_comb begin
    store_d = store_q;
    if (adv) store_d = d_enc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= 1'b0;
    else        store_q <= store_d;
  end

  assign q = INVERT ? ~store_q : store_q;
endmodule

// File: rtl/galois_tap_lfsr.sv
module galois_tap_lfsr #(
  parameter int unsigned WIDTH = glfsr_pkg::GLFSR_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [WIDTH-1:0] tap_sel,
  output logic [WIDTH-1:0] lfsr_q
);
  localparam int unsigned MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             rst_core_n;
  logic             fb;
  logic [WIDTH-1:0] link_d;

  glfsr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign fb = lfsr_q[MSB];

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        glfsr_link #(.FIRST(1'b1)) u_link (
          .prev_q (1'b0),
          .fb     (fb),
          .tap_en (tap_sel[0]),
          .link_d (link_d[0])
        );
        glfsr_stage #(.INVERT(1'b1)) u_ff (
          .clk   (clk),
          .rst_n (rst_core_n),
          .adv   (step),
          .d     (link_d[0]),
          .q     (lfsr_q[0])
        );
      end else begin : g_rest
        glfsr_link #(.FIRST(1'b0)) u_link (
          .prev_q (lfsr_q[gi-1]),
          .fb     (fb),
          .tap_en (tap_sel[gi]),
          .link_d (link_d[gi])
        );
        glfsr_stage #(.INVERT(1'b0)) u_ff (
          .clk   (clk),
          .rst_n (rst_core_n),
          .adv   (step),
          .d     (link_d[gi]),
          .q     (lfsr_q[gi])
        );
      end
    end
  endgenerate

  a_r1_seed_in_reset: assert property (@(posedge clk) !rst_n |-> lfsr_q == SEED)
    else $error("state not seeded during reset");

  a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_core_n)
    !step |=> $stable(lfsr_q))
    else $error("state moved without step");

  a_r3_head_source: assert property (@(posedge clk) disable iff (!rst_core_n)
    step |=> lfsr_q[0] == ($past(tap_sel[0]) & $past(lfsr_q[MSB])))
    else $error("stage 1 loaded wrong value");

  a_r4_body_shift: assert property (@(posedge clk) disable iff (!rst_core_n)
    step |=> lfsr_q[MSB:1] == ($past(lfsr_q[MSB-1:0]) ^
                               ($past(tap_sel[MSB:1]) & {(WIDTH-1){$past(lfsr_q[MSB])}})))
    else $error("body stages loaded wrong value");

  a_r5_zero_lock: assert property (@(posedge clk) disable iff (!rst_core_n)
    lfsr_q == '0 |=> lfsr_q == '0)
    else $error("left the all-zero state");
endmodule

// File: tb/sim_galois_tap_lfsr.sv
module sim_galois_tap_lfsr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step;
  logic [7:0] tap_sel;
  logic [7:0] lfsr_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  galois_tap_lfsr u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .tap_sel (tap_sel),
    .lfsr_q  (lfsr_q)
  );

  // {step, tap_sel, expected state after that edge}, chained from seed 8'h01
  localparam logic [16:0] VEC [17] = '{
    {1'b1, 8'h1D, 8'h02}, {1'b1, 8'h1D, 8'h04}, {1'b1, 8'hFF, 8'h08},
    {1'b1, 8'h00, 8'h10}, {1'b1, 8'h1D, 8'h20}, {1'b1, 8'h12, 8'h40},
    {1'b1, 8'h00, 8'h80}, {1'b1, 8'h1D, 8'h1D}, {1'b1, 8'h12, 8'h3A},
    {1'b1, 8'hFF, 8'h74}, {1'b1, 8'h01, 8'hE8}, {1'b1, 8'h1D, 8'hCD},
    {1'b1, 8'hFF, 8'h65}, {1'b1, 8'h12, 8'hCA}, {1'b1, 8'h01, 8'h95},
    {1'b1, 8'h00, 8'h2A}, {1'b0, 8'hFF, 8'h2A}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edge_with(input logic s, input logic [7:0] m);
    @(negedge clk);
    step    = s;
    tap_sel = m;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step  = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] ref_s;
    rst_n   = 1'b0;
    step    = 1'b0;
    tap_sel = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset seed", lfsr_q, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 seed after release", lfsr_q, 8'h01);

    // R3 R4 R2: chained vector table
    for (int i = 0; i < 17; i++) begin
      edge_with(VEC[i][16], VEC[i][15:8]);
      check($sformatf("R3/R4 vector %0d", i), lfsr_q, VEC[i][7:0]);
    end

    // R2: mask changes without step are ignored, then used on next step
    for (int i = 0; i < 4; i++) begin
      edge_with(1'b0, 8'h11 << i);
      check("R2 hold on mask change", lfsr_q, 8'h2A);
    end
    edge_with(1'b1, 8'h00);
    check("R2 new mask on next step", lfsr_q, 8'h54);

    // R1: reset wins over a held step, release delayed two edges
    @(negedge clk);
    tap_sel = 8'h1D;
    step    = 1'b1;
    #1 rst_n = 1'b0;
    #0.5 check("R1 async reset with step high", lfsr_q, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no advance at first edge after release", lfsr_q, 8'h01);
    @(negedge clk);
    check("R1 no advance at second edge after release", lfsr_q, 8'h01);
    @(negedge clk);
    check("R1 advances at third edge", lfsr_q, 8'h02);
    step = 1'b0;

    // R6: period 255
    do_reset();
    n = 0;
    for (int k = 1; k <= 300; k++) begin
      edge_with(1'b1, 8'h1D);
      if (lfsr_q == 8'h01) begin n = k; break; end
    end
    check("R6 period with 8'h1D", n, 255);

    // R7: period 127 after first step
    do_reset();
    edge_with(1'b1, 8'h12);
    check("R7 stage 1 cleared", lfsr_q[0], 1'b0);
    ref_s = lfsr_q;
    n = 0;
    for (int k = 1; k <= 200; k++) begin
      edge_with(1'b1, 8'h12);
      if (lfsr_q == ref_s) begin n = k; break; end
    end
    check("R7 period with 8'h12", n, 127);

    // R8: rotation
    do_reset();
    edge_with(1'b1, 8'h01);
    check("R8 rotate first step", lfsr_q, 8'h02);
    n = 0;
    for (int k = 2; k <= 20; k++) begin
      edge_with(1'b1, 8'h01);
      if (lfsr_q == 8'h01) begin n = k; break; end
    end
    check("R8 rotation period", n, 8);

    // R9 then R5
    do_reset();
    for (int k = 0; k < 8; k++) edge_with(1'b1, 8'h00);
    check("R9 cleared after 8 steps", lfsr_q, 8'h00);
    for (int k = 0; k < 6; k++) begin
      edge_with(1'b1, (k % 2 == 0) ? 8'hFF : 8'h1D);
      check("R5 zero lock", lfsr_q, 8'h00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule